// File: doc/BRIEF.md
# Serial Configuration Loader with Address-Routed Holding Registers

This block takes a three-wire serial programming stream (serial clock, serial data, load strobe) and turns it into four parallel configuration words for a dual-channel frequency synthesizer. The two channels each have a reference divider word and a feedback divider word. A 22-bit word is shifted in, most significant bit first. When the load strobe rises, the word is copied into one of the four holding registers. The two least significant bits of the shifted word choose which one.

All three serial inputs are brought into the system clock domain through a synchronizer of the same depth, so every input has the same delay. Edges are then found by comparing each synchronized level with its value in the previous cycle. The shift register, the holding registers and the update strobes all run on the system clock. When a holding register takes a new word, a one-cycle strobe for that register is raised in the same cycle, so a downstream block can read the fields in that register. This block only routes the word and does not decode those fields.

Top module: `serial_cfg_router`

## Requirements
- R1: While rst_ni is low, all four holding outputs read zero and upd_o is zero. Reset also clears the shift register, so a load that follows fewer than 22 serial bits holds zeros in its upper positions.
- R2: Each rising edge of ser_clk_i shifts the level of ser_data_i into the shift register, with the first bit sent ending up in bit 21. After 22 serial clocks and a load, the selected output equals the 22-bit word sent.
- R3: On a load, bits [1:0] of the shifted word select the destination. 2'b00 selects ch1_ref_o, 2'b01 selects ch1_fb_o, 2'b10 selects ch2_ref_o and 2'b11 selects ch2_fb_o. The whole 22-bit word, address bits included, is stored.
- R4: On a load, the three holding registers that are not selected keep their previous values.
- R5: Each load raises exactly one bit of upd_o, with bit index equal to the destination code of R3. That bit stays high for exactly one system clock cycle, in the first cycle in which the new word is visible.
- R6: Shifting bits while ser_le_i stays low changes no holding output and raises no upd_o bit.
- R7: When more than 22 bits are shifted before a load, only the last 22 bits sent are stored.
- R8: Holding ser_le_i high for many cycles, and its falling edge, cause no extra load and no extra strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous, oversampled) |
| ser_data_i | input | 1 | Serial data, MSB first |
| ser_le_i | input | 1 | Load strobe; rising edge transfers the word |
| ch1_ref_o | output | 22 | Channel 1 reference divider word |
| ch1_fb_o | output | 22 | Channel 1 feedback divider word |
| ch2_ref_o | output | 22 | Channel 2 reference divider word |
| ch2_fb_o | output | 22 | Channel 2 feedback divider word |
| upd_o | output | 4 | One-cycle update strobe per holding register |

## Verification
Some properties are checked by assertions on every cycle:
- a detected serial clock edge puts the synchronized data bit into the low position of the shift register;
- a load writes only the addressed register and leaves the others stable;
- the update vector has at most one bit set, and each set bit lasts a single cycle and follows a detected load edge;
- load edges never occur in two consecutive cycles.

Other properties can only be shown by the bench's scenarios, which compare the ports with words computed in the bench:
- the order in which bits arrive (MSB first);
- that only the last 22 bits survive a longer stream;
- that the shift register is really cleared by reset;
- that a long load pulse produces only one strobe.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int unsigned CFG_WORD_W      = 22;
  localparam int unsigned CFG_NUM_DEST    = 4;
  localparam int unsigned CFG_SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    DST_CH1_REF = 2'd0,
    DST_CH1_FB  = 2'd1,
    DST_CH2_REF = 2'd2,
    DST_CH2_FB  = 2'd3
  } dest_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int unsigned WORD_W = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] word_o
);
  logic              sclk_q;
  logic              shift_en;
  logic [WORD_W-1:0] word_q;

  assign shift_en = sclk_i & ~sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      word_q <= '0;
    end else begin
      sclk_q <= sclk_i;
      if (shift_en) word_q <= {word_q[WORD_W-2:0], sdata_i};
    end
  end

  assign word_o = word_q;

  AST_SHIFT_LSB_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en |=> word_q[0] == $past(sdata_i)); // R2
  AST_SHIFT_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_i |=> $stable(word_q)); // R6
endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank #(
  parameter int unsigned WORD_W   = 22,
  parameter int unsigned NUM_DEST = 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             load_i,
  input  logic [WORD_W-1:0]                word_i,
  output logic [NUM_DEST-1:0][WORD_W-1:0]  dest_o,
  output logic [NUM_DEST-1:0]              upd_o
);
  localparam int unsigned ADDR_W = $clog2(NUM_DEST);

  logic [ADDR_W-1:0]               sel;
  logic [NUM_DEST-1:0]             hit;
  logic [NUM_DEST-1:0][WORD_W-1:0] dest_q;
  logic [NUM_DEST-1:0]             upd_q;

  assign sel = word_i[ADDR_W-1:0];

  for (genvar g = 0; g < NUM_DEST; g++) begin : g_dest
    assign hit[g] = load_i && (sel == ADDR_W'(g));

    AST_ROUTE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && word_i[ADDR_W-1:0] == ADDR_W'(g)) |=> dest_q[g] == $past(word_i)); // R3
    AST_UNSEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(load_i && word_i[ADDR_W-1:0] == ADDR_W'(g)) |=> $stable(dest_q[g])); // R4
    AST_UPD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_q[g] |=> !upd_q[g]); // R5
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dest_q <= '0;
      upd_q  <= '0;
    end else begin
      upd_q <= hit;
      for (int d = 0; d < NUM_DEST; d++) begin
        if (hit[d]) dest_q[d] <= word_i;
      end
    end
  end

  assign dest_o = dest_q;
  assign upd_o  = upd_q;

  AST_UPD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(upd_q)); // R5
  AST_UPD_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_q != '0) |-> $past(load_i)); // R5
endmodule

// File: rtl/serial_cfg_router.sv
module serial_cfg_router
  import cfg_pkg::*;
#(
  parameter int unsigned WORD_W = CFG_WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_clk_i,
  input  logic              ser_data_i,
  input  logic              ser_le_i,
  output logic [WORD_W-1:0] ch1_ref_o,
  output logic [WORD_W-1:0] ch1_fb_o,
  output logic [WORD_W-1:0] ch2_ref_o,
  output logic [WORD_W-1:0] ch2_fb_o,
  output logic [CFG_NUM_DEST-1:0] upd_o
);
  logic [2:0]                          sync_q;
  logic                                s_clk, s_data, s_le;
  logic                                le_q;
  logic                                load;
  logic [WORD_W-1:0]                   word;
  logic [CFG_NUM_DEST-1:0][WORD_W-1:0] dest;

  // same depth on all three wires keeps data aligned to its clock edge
  cfg_sync #(.W(3), .STAGES(CFG_SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ser_le_i, ser_data_i, ser_clk_i}),
    .q_o   (sync_q)
  );

  assign {s_le, s_data, s_clk} = sync_q;

  cfg_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (s_clk),
    .sdata_i(s_data),
    .word_o (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) le_q <= 1'b0;
    else         le_q <= s_le;
  end

  assign load = s_le & ~le_q;

  cfg_latch_bank #(.WORD_W(WORD_W), .NUM_DEST(CFG_NUM_DEST)) u_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .word_i(word),
    .dest_o(dest),
    .upd_o (upd_o)
  );

  assign ch1_ref_o = dest[DST_CH1_REF];
  assign ch1_fb_o  = dest[DST_CH1_FB];
  assign ch2_ref_o = dest[DST_CH2_REF];
  assign ch2_fb_o  = dest[DST_CH2_FB];

  AST_LOAD_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> !load); // R8
  AST_NO_UPD_WITHOUT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_le |=> (upd_o == '0)); // R6
endmodule

// File: tb/serial_cfg_router_tb_top.sv
module serial_cfg_router_tb_top;
  localparam int W = 22;
  localparam int HALF = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ser_clk_i = 1'b0, ser_data_i = 1'b0, ser_le_i = 1'b0;
  logic [W-1:0] ch1_ref_o, ch1_fb_o, ch2_ref_o, ch2_fb_o;
  logic [3:0] upd_o;

  always #4 clk_i = ~clk_i; // 125 MHz

  serial_cfg_router dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ser_clk_i(ser_clk_i), .ser_data_i(ser_data_i), .ser_le_i(ser_le_i),
    .ch1_ref_o(ch1_ref_o), .ch1_fb_o(ch1_fb_o), .ch2_ref_o(ch2_ref_o), .ch2_fb_o(ch2_fb_o),
    .upd_o(upd_o)
  );

  int checks = 0, errors = 0, cyc = 0;
  int rise_cnt [4];
  int high_cnt [4];
  logic [3:0] upd_prev = '0;
  logic [W-1:0] model [4];
  logic [W-1:0] sr_model;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    upd_prev <= upd_o;
    for (int i = 0; i < 4; i++) begin
      if (upd_o[i]) high_cnt[i] <= high_cnt[i] + 1;
      if (upd_o[i] && !upd_prev[i]) rise_cnt[i] <= rise_cnt[i] + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] out_of(input int d);
    case (d)
      0: return ch1_ref_o;
      1: return ch1_fb_o;
      2: return ch2_ref_o;
      default: return ch2_fb_o;
    endcase
  endfunction

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic sbit(input logic b);
    ser_data_i = b;
    wait_clk(HALF);
    ser_clk_i = 1'b1;
    sr_model = {sr_model[W-2:0], b};
    wait_clk(HALF);
    ser_clk_i = 1'b0;
  endtask

  task automatic check_all(input string req);
    for (int d = 0; d < 4; d++)
      chk(out_of(d) === model[d], req, $sformatf("dest%0d", d), out_of(d), model[d]);
  endtask

  // shift the low n bits of v MSB first, then pulse load for le_hold cycles
  task automatic load_bits(input logic [63:0] v, input int n, input int le_hold,
                           input string req);
    int r0 [4];
    int h0 [4];
    int a;
    for (int i = 0; i < 4; i++) begin r0[i] = rise_cnt[i]; h0[i] = high_cnt[i]; end
    for (int i = n - 1; i >= 0; i--) sbit(v[i]);
    wait_clk(HALF);
    check_all("R6");
    for (int i = 0; i < 4; i++)
      chk(rise_cnt[i] == r0[i], "R6", $sformatf("upd%0d before load", i), rise_cnt[i], r0[i]);
    ser_le_i = 1'b1;
    wait_clk(le_hold);
    ser_le_i = 1'b0;
    wait_clk(8);
    a = int'(sr_model[1:0]);
    model[a] = sr_model;
    chk(out_of(a) === sr_model, req, $sformatf("selected dest%0d", a), out_of(a), sr_model);
    check_all("R4");
    for (int i = 0; i < 4; i++) begin
      chk(rise_cnt[i] - r0[i] == (i == a ? 1 : 0), "R5",
          $sformatf("upd%0d pulses", i), rise_cnt[i] - r0[i], (i == a ? 1 : 0));
      chk(high_cnt[i] - h0[i] == (i == a ? 1 : 0), (le_hold > 10) ? "R8" : "R5",
          $sformatf("upd%0d high cycles", i), high_cnt[i] - h0[i], (i == a ? 1 : 0));
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    ser_clk_i = 1'b0; ser_data_i = 1'b0; ser_le_i = 1'b0;
    sr_model = '0;
    for (int i = 0; i < 4; i++) model[i] = '0;
    wait_clk(3);
    check_all("R1");
    chk(upd_o == 4'b0, "R1", "upd_o in reset", upd_o, 0);
    rst_ni = 1'b1;
    wait_clk(3);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin rise_cnt[i] = 0; high_cnt[i] = 0; end
    do_reset();

    // R2/R3: explicit word per destination, compared with the literal sent
    for (int a = 0; a < 4; a++) begin
      logic [W-1:0] w;
      w = 22'h2A5A5C | W'(a);
      load_bits(64'(w), W, 4, "R3");
      chk(out_of(a) === w, "R2", $sformatf("msb-first word dest%0d", a), out_of(a), w);
    end

    // R2: walking-one sweep over every bit position and every destination
    for (int a = 0; a < 4; a++)
      for (int p = 2; p < W; p++)
        load_bits(64'((22'd1 << p) | W'(a)), W, 4, "R2");

    // R2/R3: all ones and all zeros of the payload
    for (int a = 0; a < 4; a++) begin
      load_bits(64'(22'h3FFFFC | W'(a)), W, 4, "R3");
      load_bits(64'(W'(a)), W, 4, "R3");
    end

    // R7: eight leading junk bits, only the last 22 survive
    load_bits({34'h0, 8'hFF, 22'h13579E}, W + 8, 4, "R7");
    chk(ch2_ref_o === 22'h13579E, "R7", "trailing 22 bits", ch2_ref_o, 22'h13579E);

    // R8: long load pulse, one strobe only
    load_bits(64'(22'h0F0F0D), W, 40, "R8");

    // R1: reset mid-stream, then a short 10-bit load sees a cleared shift register
    for (int i = 0; i < 7; i++) sbit(1'b1);
    do_reset();
    load_bits(64'(10'h2C1), 10, 4, "R1");
    chk(ch1_fb_o === 22'h0002C1, "R1", "short load after reset", ch1_fb_o, 22'h0002C1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk_i) begin
    if (cyc > 200000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 200000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule